// File: doc/BRIEF.md
# Prioritised Interrupt Request Controller

The controller gathers interrupt requests from seven maskable sources and one non-maskable source, and presents one request line to a processor. It detects the rising edge of each request input and records it in a pending bit. A pending bit stays set until the processor accepts that level. Maskable source k (input bit k-1) has the fixed priority level k, from 1 up to 7. The non-maskable source ranks as level 8, above every maskable source.

The controller picks the highest pending level. A maskable winner is forwarded only while the global enable is on and its level is strictly greater than the processor's mask level. A pending non-maskable request is always forwarded. The processor accepts a request by raising the acknowledge input. In the cycle after that, the controller gives a service vector computed from the accepted level. Accepting any request turns the global enable off. The processor turns it back on with a one-cycle enable pulse.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is asserted and after it, irq_o and vec_vld_o are 0, the global enable is off and no level is pending. Raising en_set_i with no request edge leaves irq_o at 0.
- R2: A 0-to-1 transition on req_i[k] marks level k+1 pending, and irq_o can rise in the following cycle. A request held high is not pending again once its level has been accepted.
- R3: When several levels are pending, the highest level wins. This decides irq_o and the vector returned for that acknowledge.
- R4: A maskable winner is forwarded only if its level is greater than mask_lvl_i. A level at or below the mask stays pending and is forwarded once the mask drops below it.
- R5: The global enable is off after reset and is set by a one-cycle pulse on en_set_i. While it is off, no maskable request drives irq_o.
- R6: A rising edge on nmi_i makes level 8 pending. Level 8 is forwarded whatever the mask or the enable, and it beats every maskable level. If nmi_i stays high, it is not serviced a second time.
- R7: irq_o is 1 when a forwardable request exists and ack_i is 0, and it is 0 in every cycle where ack_i is 1. An acknowledge while a request is forwardable clears the winner's pending bit and turns the enable off; if ack_i and en_set_i are both 1 in that cycle, the enable ends off. An acknowledge with nothing forwardable has no effect.
- R8: In the cycle after an accepted acknowledge, vec_vld_o is 1 and vec_o equals VEC_BASE plus 4 times the accepted level. With the default VEC_BASE of 0x0100, level 3 gives 0x010C and level 8 gives 0x0120.
- R9: A request edge that arrives while the enable is off, or while another request is being serviced, stays pending and is forwarded as soon as the enable is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_REQ (7) | Maskable requests; bit k has level k+1 |
| nmi_i | input | 1 | Non-maskable request, level NUM_REQ+1 |
| mask_lvl_i | input | MW (3) | Processor mask level |
| en_set_i | input | 1 | One-cycle pulse that turns the global enable on |
| ack_i | input | 1 | Interrupt acknowledge from the processor |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | VEC_W (16) | Service vector of the last accepted level |
| vec_vld_o | output | 1 | vec_o valid, one cycle after an accepted acknowledge |

## Verification
A lost or stuck pending bit shows up at the ports in one of two ways. Either irq_o stays low one cycle after an edge that should have raised it, or irq_o comes back after that level has been accepted. A wrong priority pick or a wrong mask compare does not change irq_o in every case, but vec_o reports the wrong level in the cycle after the acknowledge. An enable flag that fails to clear shows as irq_o high in the cycle right after an acceptance, when a lower level is still pending. The bench therefore checks irq_o in every cycle and the vector after every acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    SRC_MASKABLE = 1'b0,
    SRC_NMI      = 1'b1
  } irq_src_e;
endpackage

// File: rtl/irq_edge_pend.sv
module irq_edge_pend #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic rise;
    assign rise = req_i[g] & ~prev_q[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[g] <= 1'b0;
        pend_o[g] <= 1'b0;
      end else begin
        prev_q[g] <= req_i[g];
        // a fresh edge wins over a clear in the same cycle
        if (rise)          pend_o[g] <= 1'b1;
        else if (clr_i[g]) pend_o[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N  = 7,
  parameter int unsigned LW = 4
) (
  input  logic [N-1:0]  pend_i,
  output logic          any_o,
  output logic [LW-1:0] lvl_o
);
  always_comb begin
    lvl_o = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (pend_i[i]) lvl_o = LW'(i + 1);
    end
  end

  assign any_o = |pend_i;
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
  parameter int unsigned       LW       = 4,
  parameter int unsigned       VEC_W    = 16,
  parameter logic [VEC_W-1:0]  VEC_BASE = 16'h0100,
  parameter int unsigned       STEP_SH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LW-1:0]    lvl_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             vld_o
);
  logic [VEC_W-1:0] vec_d;
  assign vec_d = VEC_BASE + (VEC_W'(lvl_i) << STEP_SH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= load_i;
      if (load_i) vec_o <= vec_d;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned      NUM_REQ  = 7,
  parameter int unsigned      VEC_W    = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h0100,
  parameter int unsigned      STEP_SH  = 2,
  localparam int unsigned     MW       = $clog2(NUM_REQ + 1),
  localparam int unsigned     LW       = $clog2(NUM_REQ + 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               nmi_i,
  input  logic [MW-1:0]      mask_lvl_i,
  input  logic               en_set_i,
  input  logic               ack_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               vec_vld_o
);
  localparam logic [LW-1:0] NMI_LVL = LW'(NUM_REQ + 1);

  logic [NUM_REQ-1:0] pend, clr;
  logic               nmi_pend, nmi_clr;
  logic               m_any;
  logic [LW-1:0]      m_lvl, win_lvl;
  irq_src_e           win_src;
  logic               m_fwd, fwd, accept;
  logic               en_q;

  irq_edge_pend #(.N(NUM_REQ)) u_mpend (
    .clk_i, .rst_ni, .req_i(req_i), .clr_i(clr), .pend_o(pend)
  );

  irq_edge_pend #(.N(1)) u_npend (
    .clk_i, .rst_ni, .req_i(nmi_i), .clr_i(nmi_clr), .pend_o(nmi_pend)
  );

  irq_prio_pick #(.N(NUM_REQ), .LW(LW)) u_pick (
    .pend_i(pend), .any_o(m_any), .lvl_o(m_lvl)
  );

  assign win_src = nmi_pend ? SRC_NMI : SRC_MASKABLE;
  assign win_lvl = (win_src == SRC_NMI) ? NMI_LVL : m_lvl;

  // strict threshold: level must exceed mask
  assign m_fwd  = en_q & m_any & (m_lvl > {{(LW-MW){1'b0}}, mask_lvl_i});
  assign fwd    = nmi_pend | m_fwd;
  assign accept = ack_i & fwd;
  assign irq_o  = fwd & ~ack_i;

  assign nmi_clr = accept & (win_src == SRC_NMI);
  for (genvar g = 0; g < NUM_REQ; g++) begin : g_clr
    assign clr[g] = accept & (win_src == SRC_MASKABLE) & (m_lvl == LW'(g + 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= 1'b0;
    else if (accept)   en_q <= 1'b0;
    else if (en_set_i) en_q <= 1'b1;
  end

  irq_vec_gen #(
    .LW(LW), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .STEP_SH(STEP_SH)
  ) u_vec (
    .clk_i, .rst_ni, .load_i(accept), .lvl_i(win_lvl),
    .vec_o(vec_o), .vld_o(vec_vld_o)
  );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int unsigned MW    = 3,
  parameter int unsigned LW    = 4,
  parameter int unsigned VEC_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ack_i,
  input logic             en_set_i,
  input logic             irq_o,
  input logic             vec_vld_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             fwd,
  input logic             en_q,
  input logic             nmi_pend,
  input logic [LW-1:0]    win_lvl,
  input logic [MW-1:0]    mask_lvl_i
);
  // R7
  ack_drops_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> !irq_o);

  // R7
  ack_disables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && fwd) |=> !en_q);

  // R5
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_set_i && !ack_i) |=> en_q);

  // R5
  disabled_only_nmi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !en_q) |-> nmi_pend);

  // R4
  above_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !nmi_pend) |-> (win_lvl > {{(LW-MW){1'b0}}, mask_lvl_i}));

  // R8
  vec_follows_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && fwd) |=> vec_vld_o);

  // R8
  no_spurious_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_i && fwd) |=> !vec_vld_o);

  // R8
  vec_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o |-> (vec_o[1:0] == 2'b00));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.MW(MW), .LW(LW), .VEC_W(VEC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i), .en_set_i(en_set_i),
  .irq_o(irq_o), .vec_vld_o(vec_vld_o), .vec_o(vec_o), .fwd(fwd),
  .en_q(en_q), .nmi_pend(nmi_pend), .win_lvl(win_lvl), .mask_lvl_i(mask_lvl_i)
);

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
  localparam int BASE = 'h0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  req = '0;
  logic        nmi = 1'b0;
  logic [2:0]  mask = '0;
  logic        en_set = 1'b0;
  logic        ack = 1'b0;
  logic        irq;
  logic [15:0] vec;
  logic        vec_vld;

  int    n_chk = 0;
  int    n_bad = 0;
  string tag = "R1";

  // model state
  logic [6:0] m_prev = '0, m_pend = '0;
  logic       m_nprev = 1'b0, m_npend = 1'b0, m_en = 1'b0, m_vld = 1'b0;
  int         m_vec = 0;

  always #4 clk = ~clk;

  irq_prio_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .nmi_i(nmi),
    .mask_lvl_i(mask), .en_set_i(en_set), .ack_i(ack),
    .irq_o(irq), .vec_o(vec), .vec_vld_o(vec_vld)
  );

  function automatic int top_lvl(logic [6:0] p);
    int l = 0;
    for (int i = 0; i < 7; i++) if (p[i]) l = i + 1;
    return l;
  endfunction

  task automatic chk(string what, string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic cyc(logic [6:0] r, logic n, logic [2:0] m, logic es, logic a);
    int   wl;
    logic f, acc;
    req = r; nmi = n; mask = m; en_set = es; ack = a;
    #1;
    wl = m_npend ? 8 : top_lvl(m_pend);
    f  = m_npend || (m_en && wl > int'(m));
    chk("irq_o", tag, int'(irq), int'(f && !a));
    acc = a && f;
    @(posedge clk);
    if (acc) begin
      if (wl == 8) m_npend = 1'b0;
      else         m_pend[wl-1] = 1'b0;
    end
    m_pend = m_pend | (r & ~m_prev);
    if (n && !m_nprev) m_npend = 1'b1;
    m_prev = r; m_nprev = n;
    m_en  = acc ? 1'b0 : (es ? 1'b1 : m_en);
    m_vld = acc;
    if (acc) m_vec = BASE + 4 * wl;
    @(negedge clk);
    chk("vec_vld_o", tag, int'(vec_vld), int'(m_vld));
    if (m_vld) chk("vec_o", tag, int'(vec), m_vec);
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) cyc(req, nmi, mask, 1'b0, 1'b0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [6:0] r;
    logic       n;
    logic [2:0] m;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("irq_o in reset", "R1", int'(irq), 0);
    chk("vec_vld_o in reset", "R1", int'(vec_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);

    tag = "R1";
    cyc(7'h00, 1'b0, 3'd0, 1'b1, 1'b0);
    idle(2);
    chk("no pending after reset", "R1", int'(irq), 0);

    tag = "R2";
    cyc(7'b0000100, 1'b0, 3'd0, 1'b0, 1'b0);
    chk("edge raises irq", "R2", int'(irq), 1);
    cyc(req, 1'b0, 3'd0, 1'b0, 1'b1);
    chk("vector level 3", "R8", int'(vec), 'h010C);
    cyc(req, 1'b0, 3'd0, 1'b1, 1'b0);
    idle(2);
    chk("held request not repeated", "R2", int'(irq), 0);
    cyc(7'h00, 1'b0, 3'd0, 1'b0, 1'b0);

    tag = "R3";
    cyc(7'b0010010, 1'b0, 3'd0, 1'b0, 1'b0);
    cyc(req, 1'b0, 3'd0, 1'b0, 1'b1);
    chk("highest wins", "R3", int'(vec), BASE + 20);
    cyc(req, 1'b0, 3'd0, 1'b1, 1'b0);
    cyc(req, 1'b0, 3'd0, 1'b0, 1'b1);
    chk("next level follows", "R3", int'(vec), BASE + 8);
    cyc(7'h00, 1'b0, 3'd0, 1'b1, 1'b0);

    tag = "R4";
    cyc(7'b0010000, 1'b0, 3'd5, 1'b0, 1'b0);
    idle(2);
    chk("at mask held back", "R4", int'(irq), 0);
    cyc(req, 1'b0, 3'd4, 1'b0, 1'b0);
    chk("mask lowered forwards", "R4", int'(irq), 1);
    cyc(req, 1'b0, 3'd4, 1'b0, 1'b1);
    cyc(7'h00, 1'b0, 3'd0, 1'b0, 1'b0);

    tag = "R5";
    cyc(7'b0100000, 1'b0, 3'd0, 1'b0, 1'b0);
    idle(2);
    chk("disabled blocks maskable", "R5", int'(irq), 0);
    tag = "R9";
    cyc(req, 1'b0, 3'd0, 1'b1, 1'b0);
    chk("latched while disabled", "R9", int'(irq), 1);
    cyc(req, 1'b0, 3'd0, 1'b0, 1'b1);
    cyc(7'h00, 1'b0, 3'd0, 1'b0, 1'b0);

    tag = "R6";
    cyc(7'b1000000, 1'b1, 3'd7, 1'b0, 1'b0);
    chk("nmi ignores mask and enable", "R6", int'(irq), 1);
    cyc(req, 1'b1, 3'd7, 1'b0, 1'b1);
    chk("nmi vector", "R8", int'(vec), 'h0120);
    cyc(req, 1'b1, 3'd0, 1'b1, 1'b0);
    chk("maskable after nmi", "R6", int'(irq), 1);
    cyc(req, 1'b1, 3'd0, 1'b0, 1'b1);
    chk("level 7 vector", "R8", int'(vec), BASE + 28);
    cyc(req, 1'b1, 3'd0, 1'b1, 1'b0);
    idle(2);
    chk("held nmi not repeated", "R6", int'(irq), 0);

    tag = "R7";
    cyc(7'h00, 1'b0, 3'd0, 1'b0, 1'b1);
    chk("ack without request", "R7", int'(vec_vld), 0);
    cyc(7'b0000001, 1'b0, 3'd0, 1'b1, 1'b0);
    cyc(req, 1'b0, 3'd0, 1'b1, 1'b1);
    chk("ack beats enable pulse", "R7", int'(irq), 0);

    tag = "R3";
    r = '0; n = 1'b0; m = '0;
    for (int i = 0; i < 4000; i++) begin
      for (int b = 0; b < 7; b++) if ($urandom_range(7) == 0) r[b] = ~r[b];
      if ($urandom_range(31) == 0) n = ~n;
      if ((i % 16) == 0) m = 3'($urandom_range(7));
      cyc(r, n, m, ($urandom_range(9) == 0), ($urandom_range(3) == 0));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule